// File: doc/BRIEF.md
# Dual-Plane Pixel Source Selector

This block sits in a display scan-out path, after the memory fetch logic. For every pixel position it receives three values on one valid/ready stream: a byte from an 8-bit indexed plane, a word from a 32-bit true-colour plane and a word from a 32-bit per-pixel control plane. The control word chooses the source of the pixel. If its top byte is the direct-colour tag, the colour comes straight from the true-colour word. Otherwise the index byte goes to an external palette read port and the palette entry is used.

The resulting colour leaves as a 32-bit pixel with a zero top byte. The order of the three colour bytes is selected per pixel. The output stream also marks the first pixel of each frame and the last pixel of each line. The active area comes from 16-bit width and height inputs and is clamped to 1024 by 768. The palette has one cycle of read latency. The pipeline keeps the pixels in order, moves one pixel per cycle when nothing stalls, and stops as a whole when the output is back-pressured.

Top module: `plane_pix_sel`

## Requirements
- R1: While rst_ni is low and right after it rises, out_valid_o is 0 and in_ready_o is 1.
- R2: Plane words arrive big-endian: memory byte 0 is in bits [31:24]. A pixel is direct when control bits [31:24] equal 8'h03. In a direct pixel the true-colour word holds pad in [31:24], blue in [23:16], green in [15:8] and red in [7:0]. With the byte-order select at 0 the output is {8'h00, red, green, blue}.
- R3: For any other control top byte, the pixel is the palette entry at the index byte. pal_data_i carries {red[23:16], green[15:8], blue[7:0]} and is packed as in R2.
- R4: When bgr_i is 1 at the cycle a pixel is accepted, that pixel is packed as {8'h00, blue, green, red}. This holds for both direct and palette pixels.
- R5: Control bits [23:0] and the true-colour pad byte have no effect on the output pixel.
- R6: Pixels leave in the order they were accepted. A pixel accepted at clock edge k is on the output after edge k+1 if the output is not stalled. With no stall, one pixel is accepted and one delivered every cycle.
- R7: out_sof_o is 1 exactly on the first pixel of every frame: position (0,0), counted over accepted pixels.
- R8: out_eol_o is 1 exactly on the pixel at column width_i-1. After height_i lines, the next pixel starts a new frame.
- R9: While out_valid_o is 1 and out_ready_i is 0, the output pixel and its flags hold steady. No pixel is dropped or repeated.
- R10: pal_en_o is 1 only in a cycle where an input pixel is accepted, and pal_addr_o is then that pixel's index byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| width_i | input | 16 | Active pixels per line |
| height_i | input | 16 | Active lines per frame |
| bgr_i | input | 1 | 1 selects blue-green-red output byte order |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Input pixel accepted when high with valid |
| in_index_i | input | 8 | Indexed-plane byte |
| in_true_i | input | 32 | True-colour plane word |
| in_ctrl_i | input | 32 | Control plane word |
| pal_en_o | output | 1 | Palette read enable |
| pal_addr_o | output | 8 | Palette read address |
| pal_data_i | input | 24 | Palette entry, valid the cycle after a read |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Output consumer ready |
| out_pixel_o | output | 32 | Packed output pixel |
| out_sof_o | output | 1 | First pixel of a frame |
| out_eol_o | output | 1 | Last pixel of a line |

## Verification
All 256 index values are sent. Across them the control top byte cycles through 8'h03 and the near misses 8'h00, 8'h02, 8'h04, 8'h83 and 8'hFF, so the test shows that only an exact tag match selects direct colour. The low control bytes and the pad byte change with every pixel to show that they have no effect. The byte-order select flips every fifty pixels, in both modes. A small 5 by 3 active area makes many line and frame wraps. Input gaps and irregular output stalls show that ordering holds, that stalled outputs hold steady and that palette data stays lined up with its pixel.

// File: rtl/plane_pix_pkg.sv
package plane_pix_pkg;
  localparam logic [7:0] DIRECT_TAG = 8'h03;

  typedef struct packed {
    logic        direct;
    logic        bgr;
    logic [23:0] rgb;   // {r, g, b}, direct pixels only
    logic        sof;
    logic        eol;
  } pix_meta_t;

  function automatic logic [31:0] pack_px(input logic [23:0] rgb, input logic bgr);
    return bgr ? {8'h00, rgb[7:0], rgb[15:8], rgb[23:16]} : {8'h00, rgb};
  endfunction
endpackage

// File: rtl/pix_decode.sv
module pix_decode (
  input  logic [7:0]  ctrl_tag_i,
  input  logic [23:0] true_lo_i,
  output logic        direct_o,
  output logic [23:0] rgb_o
);
  import plane_pix_pkg::*;

  assign direct_o = (ctrl_tag_i == DIRECT_TAG);
  // memory order pad,b,g,r -> {r,g,b}
  assign rgb_o    = {true_lo_i[7:0], true_lo_i[15:8], true_lo_i[23:16]};
endmodule

// File: rtl/pix_pos_ctr.sv
module pix_pos_ctr #(
  parameter int MAX_W = 1024,
  parameter int MAX_H = 768
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        step_i,
  input  logic [15:0] width_i,
  input  logic [15:0] height_i,
  output logic        sof_o,
  output logic        eol_o
);
  localparam int XW = $clog2(MAX_W);
  localparam int YW = $clog2(MAX_H);
  localparam logic [XW-1:0] X_ONE = 1;
  localparam logic [YW-1:0] Y_ONE = 1;

  logic [XW-1:0] x_q;
  logic [YW-1:0] y_q;
  logic [15:0]   w_lim, h_lim;
  logic          last_x, last_y;

  always_comb begin
    w_lim  = (width_i  > 16'(MAX_W)) ? 16'(MAX_W) : width_i;
    h_lim  = (height_i > 16'(MAX_H)) ? 16'(MAX_H) : height_i;
    last_x = (16'(x_q) + 16'd1) >= w_lim;
    last_y = (16'(y_q) + 16'd1) >= h_lim;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
      y_q <= '0;
    end else if (step_i) begin
      if (last_x) begin
        x_q <= '0;
        y_q <= last_y ? '0 : y_q + Y_ONE;
      end else begin
        x_q <= x_q + X_ONE;
      end
    end
  end

  assign sof_o = (x_q == '0) && (y_q == '0);
  assign eol_o = last_x;

  // R8
  eol_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && eol_o) |=> (x_q == '0));
  // R7
  frame_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && eol_o && last_y) |=> sof_o);
endmodule

// File: rtl/plane_pix_sel.sv
module plane_pix_sel #(
  parameter int MAX_W  = 1024,
  parameter int MAX_H  = 768,
  parameter int IDX_W  = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       width_i,
  input  logic [15:0]       height_i,
  input  logic              bgr_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [IDX_W-1:0]  in_index_i,
  input  logic [WORD_W-1:0] in_true_i,
  input  logic [WORD_W-1:0] in_ctrl_i,
  output logic              pal_en_o,
  output logic [IDX_W-1:0]  pal_addr_o,
  input  logic [23:0]       pal_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [31:0]       out_pixel_o,
  output logic              out_sof_o,
  output logic              out_eol_o
);
  import plane_pix_pkg::*;

  localparam int TAG_LSB = WORD_W - 8;

  logic        en, acc;
  logic        dir_d, sof_d, eol_d;
  logic [23:0] rgb_d;
  logic        a_valid_q;
  pix_meta_t   a_meta_q;
  logic        out_valid_q, out_sof_q, out_eol_q;
  logic [31:0] out_pixel_q;
  logic        unused_bits;

  assign unused_bits = ^{in_ctrl_i[TAG_LSB-1:0], in_true_i[WORD_W-1:24]};

  // single enable: whole pipe advances unless the output is stalled
  assign en         = !out_valid_q || out_ready_i;
  assign acc        = in_valid_i && en;
  assign in_ready_o = en;
  assign pal_en_o   = acc;
  assign pal_addr_o = in_index_i;

  pix_decode u_decode (
    .ctrl_tag_i (in_ctrl_i[WORD_W-1:TAG_LSB]),
    .true_lo_i  (in_true_i[23:0]),
    .direct_o   (dir_d),
    .rgb_o      (rgb_d)
  );

  pix_pos_ctr #(.MAX_W(MAX_W), .MAX_H(MAX_H)) u_pos (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (acc),
    .width_i  (width_i),
    .height_i (height_i),
    .sof_o    (sof_d),
    .eol_o    (eol_d)
  );

  // stage A: waits for palette read data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_valid_q <= 1'b0;
      a_meta_q  <= '0;
    end else if (en) begin
      a_valid_q <= in_valid_i;
      if (in_valid_i) a_meta_q <= '{direct: dir_d, bgr: bgr_i, rgb: rgb_d, sof: sof_d, eol: eol_d};
    end
  end

  // output stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_pixel_q <= '0;
      out_sof_q   <= 1'b0;
      out_eol_q   <= 1'b0;
    end else if (en) begin
      out_valid_q <= a_valid_q;
      if (a_valid_q) begin
        out_pixel_q <= pack_px(a_meta_q.direct ? a_meta_q.rgb : pal_data_i, a_meta_q.bgr);
        out_sof_q   <= a_meta_q.sof;
        out_eol_q   <= a_meta_q.eol;
      end
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_pixel_o = out_pixel_q;
  assign out_sof_o   = out_sof_q;
  assign out_eol_o   = out_eol_q;

  // R9
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_pixel_o) && $stable(out_sof_o) && $stable(out_eol_o)));
  // R6
  pipe_flow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> a_valid_q);
  // R6
  pipe_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_valid_q && in_ready_o) |=> out_valid_o);
endmodule

// File: tb/plane_pix_sel_bench.sv
`timescale 1ns/1ps
module plane_pix_sel_bench;
  localparam int N_PIX = 420;
  localparam int W = 5;
  localparam int H = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] width_i = 16'(W);
  logic [15:0] height_i = 16'(H);
  logic        bgr_i = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [7:0]  in_index_i = '0;
  logic [31:0] in_true_i = '0;
  logic [31:0] in_ctrl_i = '0;
  logic        pal_en_o;
  logic [7:0]  pal_addr_o;
  logic [23:0] pal_data_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic [31:0] out_pixel_o;
  logic        out_sof_o, out_eol_o;

  int n_chk = 0, n_bad = 0;

  always #4 clk_i = ~clk_i;

  plane_pix_sel u_plane_pix_sel (.*);

  function automatic logic [23:0] pal_fn(input logic [7:0] a);
    return {a ^ 8'hA5, a + 8'd17, ~a};
  endfunction

  // palette: synchronous read with enable, output holds otherwise
  always_ff @(posedge clk_i) if (pal_en_o) pal_data_i <= pal_fn(pal_addr_o);

  function automatic logic [7:0] tag_of(input int i);
    case (i % 6)
      0: return 8'h03; 1: return 8'h00; 2: return 8'h02;
      3: return 8'h04; 4: return 8'h83; default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [31:0] exp_fn(input int i);
    logic [7:0] r, g, b;
    logic [23:0] p;
    if (tag_of(i) == 8'h03) begin
      r = 8'(i ^ 8'h3C); g = 8'(i * 13); b = 8'(i * 7);   // R2
    end else begin
      p = pal_fn(8'(i)); r = p[23:16]; g = p[15:8]; b = p[7:0]; // R3
    end
    return (((i / 50) % 2) == 1) ? {8'h00, b, g, r} : {8'h00, r, g, b}; // R4
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    int n_in = 0, n_out = 0, cyc = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit hold_pend = 0;
    logic [33:0] held = '0;
    logic [31:0] e;
    logic e_sof, e_eol;

    repeat (3) @(negedge clk_i);
    // R1
    chk(out_valid_o == 1'b0, "R1 valid in reset", 32'(out_valid_o), 32'd0);
    chk(in_ready_o == 1'b1, "R1 ready in reset", 32'(in_ready_o), 32'd1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R1 valid after reset", 32'(out_valid_o), 32'd0);

    while (n_out < N_PIX && cyc < 5000) begin
      @(negedge clk_i);
      cyc++;
      out_ready_i = (cyc < 60) ? 1'b1 : (lfsr[0] | lfsr[3]);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      #1;
      if (hold_pend) // R9
        chk(out_valid_o && {out_sof_o, out_eol_o, out_pixel_o} == held, "R9 stall hold",
            out_pixel_o, held[31:0]);
      hold_pend = out_valid_o && !out_ready_i;
      held = {out_sof_o, out_eol_o, out_pixel_o};
      if (out_valid_o && out_ready_i) begin
        // R5 R6: order and value, with varying low control and pad bytes
        e = exp_fn(n_out);
        e_sof = (n_out % (W * H)) == 0;   // R7
        e_eol = (n_out % W) == W - 1;     // R8
        chk(out_pixel_o == e, "R2 R3 R4 R5 R6 pixel", out_pixel_o, e);
        chk(out_sof_o == e_sof, "R7 sof", 32'(out_sof_o), 32'(e_sof));
        chk(out_eol_o == e_eol, "R8 eol", 32'(out_eol_o), 32'(e_eol));
        n_out++;
      end
      if (n_in < N_PIX && (cyc % 7) != 3) begin
        in_valid_i = 1'b1;
        in_index_i = 8'(n_in);
        in_ctrl_i  = {tag_of(n_in), 24'(n_in * 24'h010203)};
        in_true_i  = {8'(n_in * 5), 8'(n_in * 7), 8'(n_in * 13), 8'(n_in ^ 8'h3C)};
        bgr_i      = ((n_in / 50) % 2) == 1;
      end else begin
        in_valid_i = 1'b0;
      end
      #1;
      if (in_valid_i && in_ready_o) begin
        // R10
        chk(pal_en_o && pal_addr_o == in_index_i, "R10 palette read", {23'd0, pal_en_o, pal_addr_o},
            {23'd1, in_index_i});
        n_in++;
      end else if (pal_en_o) begin
        chk(1'b0, "R10 spurious read", 32'(pal_en_o), 32'd0);
      end
    end
    in_valid_i = 1'b0;
    if (n_out < N_PIX) chk(1'b0, "watchdog", 32'(n_out), 32'(N_PIX));
    repeat (3) @(negedge clk_i);
    // R6: nothing extra emerges
    chk(out_valid_o == 1'b0, "R6 no duplicate", 32'(out_valid_o), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule